// File: doc/BRIEF.md
# UART Interrupt and Line-Status Controller

This block holds the status and interrupt logic of a 16550-style UART with 32-entry receive and transmit queues. The queue storage, the serializers and the baud logic sit outside it. They report events to it: a character pushed or popped together with its break, framing and parity flags, a lost character (overrun), and the fill level compared with a trigger level. They also report the holding and shift-register empty conditions, a modem-status change, a received Xoff and the level of the active-low RTS pin. From these the block keeps a line-status byte, a seven-bit interrupt-enable register and a set of pending interrupt sources. It combines them into one interrupt output.

A small register port gives the host access. Address 0 is the enable register (read/write). Address 1 is the line-status byte. Reading address 2 returns the raw pending vector. Reading address 3 acknowledges a modem-status change. Reads have side effects only when the read strobe is high. The read data always shows the addressed register, combinationally.

Receive errors can be reported in one of two ways, selected by a mode input. In the first, the error is reported when the faulty character becomes the head of the receive queue. In the second, it is reported on the cycle the character arrives. With every enable bit cleared, the host can poll the line-status byte alone.

Top module: `uart_isr_ctrl`

## Requirements
- R1: After reset the enable register reads 0, `irq` and `sleep_en` are low, and the overrun flag, the error flags and all pending sources are clear. While the enable register is 0, `irq` stays low whatever events arrive.
- R2: Line-status bit 0 is 1 exactly while the block's character count is non-zero. The count rises by one on `rx_push` (ignored at 32 held) and falls by one on `rx_pop` (ignored at 0).
- R3: `rx_overrun` sets line-status bit 1 and the line-status pending source on the next cycle. A line-status read (`reg_rd` at address 1) clears both, unless a new overrun arrives in the same cycle.
- R4: Line-status bits 4, 3 and 2 show `rx_head_flags` bits 2 (break), 1 (framing) and 0 (parity) while a character is held, and read 0 when the count is 0.
- R5: Line-status bit 5 equals `tx_hold_empty`. Bit 6 is 1 only when both `tx_hold_empty` and `tx_shift_empty` are 1.
- R6: Line-status bit 7 is 1 while at least one held character carries a non-zero flag set. It is counted on push and discounted on pop using the head flags, and it clears once the last errored character is popped.
- R7: With `err_on_arrival`=0, the line-status source is set one cycle after an errored character becomes the head, either pushed into an empty queue or exposed by a pop. With `err_on_arrival`=1, it is set one cycle after an errored character is pushed. A line-status read clears it.
- R8: The receive source is `rx_trig_hit` when `fifo_en`=1, and "count non-zero" when `fifo_en`=0. It stays active while that level holds and needs no acknowledge.
- R9: The transmit condition is `tx_below_trig` when `fifo_en`=1, or `tx_hold_empty` when `fifo_en`=0. The transmit source is set on a rising edge of this condition. It is also set at once when enable bit 1 is written from 0 to 1 while the condition is true. `thr_wr` or a read of address 2 clears it.
- R10: A write to address 0 always updates enable bits 3:0. Bits 6:4 are updated only when `enh_en`=1, and otherwise keep their value. `sleep_en` mirrors bit 4.
- R11: `msr_change` sets the modem source, which a read of address 3 clears. `xoff_rx` sets the Xoff source, and a low-to-high edge of `rts_n` sets the RTS source; a read of address 2 clears both. In every case a set in the same cycle wins over the clear.
- R12: `irq` is the OR of each pending source ANDed with its enable. The receive, transmit, line-status and modem sources use enable bits 0 to 3; Xoff and RTS use bits 5 and 6. Address 2 reads {0, 0, rts, xoff, modem, line, tx, rx} and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queue mode (1) or single-holding-register mode (0) |
| err_on_arrival | input | 1 | Receive error report point: 0 at head, 1 at arrival |
| enh_en | input | 1 | Permits writes to enable bits 6:4 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 7 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| rx_push | input | 1 | A character entered the receive queue |
| rx_push_flags | input | 3 | Its flags: [2] break, [1] framing, [0] parity |
| rx_pop | input | 1 | The head character was removed |
| rx_head_flags | input | 3 | Flags of the current head character |
| rx_overrun | input | 1 | A character was lost |
| rx_trig_hit | input | 1 | Receive level at or above trigger |
| tx_hold_empty | input | 1 | Transmit holding register / queue empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_below_trig | input | 1 | Transmit level below trigger |
| thr_wr | input | 1 | Host wrote transmit data |
| msr_change | input | 1 | Modem status changed |
| xoff_rx | input | 1 | Xoff character received |
| rts_n | input | 1 | Active-low RTS pin level |
| sleep_en | output | 1 | Sleep enable (enable bit 4) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check a set of invariants. The error count never exceeds the character count. An overrun, an arrival-mode error or an event strobe raises its flag on the next cycle. Enabling the transmit source while its condition holds pends it at once. Enable bits 6:4 hold still when writes to them are not permitted, and an all-zero enable register keeps `irq` low. Other properties need the bench's reference model, which keeps its own queue of per-character flags. These are the head-arrival report point across pops, the error-in-queue bit clearing only after the last errored pop, the exact clearing by each read address, and edge versus level behaviour of the transmit and RTS sources.

// File: rtl/uart_isr_pkg.sv
package uart_isr_pkg;

    typedef enum logic [1:0] {
        ADDR_IER  = 2'd0,
        ADDR_LSR  = 2'd1,
        ADDR_PEND = 2'd2,
        ADDR_MSR  = 2'd3
    } reg_addr_e;

    // Pending interrupt sources, bit 0 = rx ... bit 5 = rts
    typedef struct packed {
        logic rts;
        logic xoff;
        logic modem;
        logic line;
        logic tx;
        logic rx;
    } pend_t;

    localparam int unsigned N_EVT = 3;  // modem, xoff, rts latches

endpackage

// File: rtl/isr_evt_latch.sv
module isr_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R11
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/isr_rx_status.sv
module isr_rx_status #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [2:0] push_flags_i,
    input  logic       pop_i,
    input  logic [2:0] head_flags_i,
    input  logic       overrun_i,
    input  logic       arrival_mode_i,
    input  logic       lsr_rd_i,
    output logic       data_rdy_o,
    output logic       ovr_o,
    output logic [2:0] head_err_o,
    output logic       any_err_o,
    output logic       line_pend_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] ecnt;
        logic          ovr;
        logic          lpend;
        logic          hd_err;
        logic          popped;
    } rx_st_t;

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    rx_st_t s_d, s_q;
    logic   do_push, do_pop, head_now, report;

    always_comb begin
        s_d      = s_q;
        do_push  = push_i && (s_q.cnt != FULL);
        do_pop   = pop_i && (s_q.cnt != '0);
        head_now = (s_q.cnt != '0) && (head_flags_i != 3'b000);

        s_d.cnt  = s_q.cnt + CW'(do_push) - CW'(do_pop);
        s_d.ecnt = s_q.ecnt + CW'(do_push && (push_flags_i != 3'b000))
                            - CW'(do_pop && (head_flags_i != 3'b000));

        if (lsr_rd_i)  s_d.ovr = 1'b0;
        if (overrun_i) s_d.ovr = 1'b1;

        if (arrival_mode_i) report = do_push && (push_flags_i != 3'b000);
        else                report = head_now && (!s_q.hd_err || s_q.popped);

        if (lsr_rd_i)             s_d.lpend = 1'b0;
        if (overrun_i || report)  s_d.lpend = 1'b1;

        s_d.hd_err = head_now;
        s_d.popped = do_pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_rdy_o  = (s_q.cnt != '0);
    assign ovr_o       = s_q.ovr;
    assign head_err_o  = (s_q.cnt != '0) ? head_flags_i : 3'b000;
    assign any_err_o   = (s_q.ecnt != '0);
    assign line_pend_o = s_q.lpend;

    // R6
    ecnt_le_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ecnt <= s_q.cnt);
    // R3
    ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |=> (ovr_o && line_pend_o));
    // R7
    arrival_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arrival_mode_i && push_i && (push_flags_i != 3'b000) && (s_q.cnt != FULL))
        |=> line_pend_o);

endmodule

// File: rtl/isr_tx_status.sv
module isr_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode_i,
    input  logic below_trig_i,
    input  logic hold_empty_i,
    input  logic thr_wr_i,
    input  logic iir_rd_i,
    input  logic en_rise_i,
    output logic tx_pend_o
);
    typedef struct packed {
        logic cond;
        logic pend;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic   cond_now;

    always_comb begin
        s_d      = s_q;
        cond_now = fifo_mode_i ? below_trig_i : hold_empty_i;
        if (thr_wr_i || iir_rd_i) s_d.pend = 1'b0;
        if ((cond_now && !s_q.cond) || (en_rise_i && cond_now)) s_d.pend = 1'b1;
        s_d.cond = cond_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cond: 1'b1, pend: 1'b0};
        else        s_q <= s_d;
    end

    assign tx_pend_o = s_q.pend;

    // R9
    tx_enable_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise_i && cond_now) |=> tx_pend_o);
    // R9
    tx_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_wr_i || iir_rd_i) && !cond_now) |=> !tx_pend_o);

endmodule

// File: rtl/uart_isr_ctrl.sv
module uart_isr_ctrl
    import uart_isr_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       err_on_arrival,
    input  logic       enh_en,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [6:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rx_push,
    input  logic [2:0] rx_push_flags,
    input  logic       rx_pop,
    input  logic [2:0] rx_head_flags,
    input  logic       rx_overrun,
    input  logic       rx_trig_hit,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    input  logic       tx_below_trig,
    input  logic       thr_wr,
    input  logic       msr_change,
    input  logic       xoff_rx,
    input  logic       rts_n,
    output logic       sleep_en,
    output logic       irq
);
    typedef struct packed {
        logic [6:0] ier;
        logic       rts_n_prev;
    } top_st_t;

    top_st_t   s_d, s_q;
    reg_addr_e addr;
    logic      lsr_rd, iir_rd, msr_rd, ier_wr, en_rise, rts_rise;
    logic      data_rdy, ovr, any_err, line_pend, tx_pend;
    logic [2:0] head_err;
    logic [N_EVT-1:0] evt_set, evt_clr, evt_flag;
    pend_t     pend;
    logic [7:0] lsr;

    always_comb begin
        addr     = reg_addr_e'(reg_addr);
        lsr_rd   = reg_rd && (addr == ADDR_LSR);
        iir_rd   = reg_rd && (addr == ADDR_PEND);
        msr_rd   = reg_rd && (addr == ADDR_MSR);
        ier_wr   = reg_wr && (addr == ADDR_IER);
        en_rise  = ier_wr && reg_wdata[1] && !s_q.ier[1];
        rts_rise = rts_n && !s_q.rts_n_prev;

        s_d            = s_q;
        s_d.rts_n_prev = rts_n;
        if (ier_wr) begin
            s_d.ier[3:0] = reg_wdata[3:0];
            if (enh_en) s_d.ier[6:4] = reg_wdata[6:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ier: 7'd0, rts_n_prev: 1'b1};
        else        s_q <= s_d;
    end

    isr_rx_status #(.DEPTH(DEPTH)) i_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .push_i         (rx_push),
        .push_flags_i   (rx_push_flags),
        .pop_i          (rx_pop),
        .head_flags_i   (rx_head_flags),
        .overrun_i      (rx_overrun),
        .arrival_mode_i (err_on_arrival),
        .lsr_rd_i       (lsr_rd),
        .data_rdy_o     (data_rdy),
        .ovr_o          (ovr),
        .head_err_o     (head_err),
        .any_err_o      (any_err),
        .line_pend_o    (line_pend)
    );

    isr_tx_status i_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_mode_i  (fifo_en),
        .below_trig_i (tx_below_trig),
        .hold_empty_i (tx_hold_empty),
        .thr_wr_i     (thr_wr),
        .iir_rd_i     (iir_rd),
        .en_rise_i    (en_rise),
        .tx_pend_o    (tx_pend)
    );

    // event index 0 = modem, 1 = xoff, 2 = rts
    assign evt_set = {rts_rise, xoff_rx, msr_change};
    assign evt_clr = {iir_rd, iir_rd, msr_rd};

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        isr_evt_latch i_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_set[g]),
            .clr_i  (evt_clr[g]),
            .flag_o (evt_flag[g])
        );
    end

    always_comb begin
        pend.rx    = fifo_en ? rx_trig_hit : data_rdy;
        pend.tx    = tx_pend;
        pend.line  = line_pend;
        pend.modem = evt_flag[0];
        pend.xoff  = evt_flag[1];
        pend.rts   = evt_flag[2];

        lsr = {any_err, tx_hold_empty && tx_shift_empty, tx_hold_empty,
               head_err, ovr, data_rdy};

        unique case (addr)
            ADDR_IER:  reg_rdata = {1'b0, s_q.ier};
            ADDR_LSR:  reg_rdata = lsr;
            ADDR_PEND: reg_rdata = {2'b00, pend};
            default:   reg_rdata = 8'h00;
        endcase

        irq = (pend.rx    && s_q.ier[0]) || (pend.tx   && s_q.ier[1]) ||
              (pend.line  && s_q.ier[2]) || (pend.modem && s_q.ier[3]) ||
              (pend.xoff  && s_q.ier[5]) || (pend.rts  && s_q.ier[6]);
    end

    assign sleep_en = s_q.ier[4];

    // R10
    enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd0) && !enh_en) |=> $stable(s_q.ier[6:4]));
    // R1
    polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ier == 7'd0) |-> !irq);

endmodule

// File: tb/test_uart_isr_ctrl.sv
module test_uart_isr_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, err_on_arrival = 1'b0, enh_en = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [6:0] reg_wdata = 7'd0;
    logic [7:0] reg_rdata;
    logic       rx_push = 1'b0, rx_pop = 1'b0, rx_overrun = 1'b0, rx_trig_hit = 1'b0;
    logic [2:0] rx_push_flags = 3'd0, rx_head_flags = 3'd0;
    logic       tx_hold_empty = 1'b1, tx_shift_empty = 1'b1, tx_below_trig = 1'b0;
    logic       thr_wr = 1'b0, msr_change = 1'b0, xoff_rx = 1'b0, rts_n = 1'b1;
    logic       sleep_en, irq;

    always #10 clk = ~clk;

    uart_isr_ctrl i_uart_isr_ctrl (.*);

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int   q_flags[$];
    int   q_ser[$];
    int   next_ser = 0, last_ser = -1;
    bit   m_ovr = 0, m_lpend = 0, m_txp = 0, m_cond_prev = 1;
    bit   m_ms = 0, m_xo = 0, m_rt = 0, m_rts_prev = 1;
    int   m_ier = 0;

    task automatic chk(string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
        end
    endtask

    function automatic int exp_pend();
        int rxp, rdy;
        rdy = (q_flags.size() != 0);
        rxp = fifo_en ? int'(rx_trig_hit) : rdy;
        return rxp | (int'(m_txp) << 1) | (int'(m_lpend) << 2) |
               (int'(m_ms) << 3) | (int'(m_xo) << 4) | (int'(m_rt) << 5);
    endfunction

    function automatic int exp_rdata();
        int rdy, head, ferr, lsr;
        rdy  = (q_flags.size() != 0);
        head = rdy ? q_flags[0] : 0;
        ferr = 0;
        foreach (q_flags[i]) if (q_flags[i] != 0) ferr = 1;
        lsr = rdy | (int'(m_ovr) << 1) | (head << 2) | (int'(tx_hold_empty) << 5) |
              (int'(tx_hold_empty && tx_shift_empty) << 6) | (ferr << 7);
        case (reg_addr)
            2'd0:    return m_ier;
            2'd1:    return lsr;
            2'd2:    return exp_pend();
            default: return 0;
        endcase
    endfunction

    function automatic int exp_irq();
        int p, en;
        p  = exp_pend();
        en = (m_ier & 15) | ((m_ier >> 1) & 48);  // ier5->bit4, ier6->bit5
        return ((p & en) != 0) ? 1 : 0;
    endfunction

    task automatic model_step();
        bit cond, en_rise, lsr_rd, iir_rd, msr_rd, rdy, report;
        lsr_rd = reg_rd && reg_addr == 2'd1;
        iir_rd = reg_rd && reg_addr == 2'd2;
        msr_rd = reg_rd && reg_addr == 2'd3;
        cond = fifo_en ? tx_below_trig : tx_hold_empty;
        en_rise = reg_wr && reg_addr == 2'd0 && reg_wdata[1] && !m_ier[1];
        if (thr_wr || iir_rd) m_txp = 0;
        if ((cond && !m_cond_prev) || (en_rise && cond)) m_txp = 1;
        m_cond_prev = cond;
        rdy = (q_flags.size() != 0);
        report = 0;
        if (!err_on_arrival && rdy && q_flags[0] != 0 && q_ser[0] != last_ser) report = 1;
        if (err_on_arrival && rx_push && rx_push_flags != 0 && q_flags.size() < 32) report = 1;
        last_ser = rdy ? q_ser[0] : -1;
        if (lsr_rd) begin m_ovr = 0; m_lpend = 0; end
        if (rx_overrun) m_ovr = 1;
        if (rx_overrun || report) m_lpend = 1;
        if (msr_rd) m_ms = 0;
        if (iir_rd) begin m_xo = 0; m_rt = 0; end
        if (msr_change) m_ms = 1;
        if (xoff_rx) m_xo = 1;
        if (rts_n && !m_rts_prev) m_rt = 1;
        m_rts_prev = rts_n;
        if (reg_wr && reg_addr == 2'd0) begin
            m_ier = (m_ier & 'h70) | (reg_wdata & 'h0F);
            if (enh_en) m_ier = (m_ier & 'h0F) | (reg_wdata & 'h70);
        end
        if (rx_pop && rdy) begin void'(q_flags.pop_front()); void'(q_ser.pop_front()); end
        if (rx_push && q_flags.size() < 32) begin
            q_flags.push_back(int'(rx_push_flags));
            q_ser.push_back(next_ser);
            next_ser++;
        end
    endtask

    // one cycle: compare, clock, update model, clear strobes
    task automatic tick();
        #1;
        chk("rdata", int'(reg_rdata), exp_rdata());
        chk("irq", int'(irq), exp_irq());
        chk("sleep_en", int'(sleep_en), (m_ier >> 4) & 1);
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; rx_push = 0; rx_pop = 0; rx_overrun = 0;
        thr_wr = 0; msr_change = 0; xoff_rx = 0; rx_push_flags = 0;
        rx_head_flags = (q_flags.size() != 0) ? 3'(q_flags[0]) : 3'd0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_ier(int v);
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 7'(v); tick();
    endtask

    task automatic rd(int a);
        reg_rd = 1; reg_addr = 2'(a); tick();
    endtask

    task automatic push(int f);
        rx_push = 1; rx_push_flags = 3'(f); tick();
    endtask

    task automatic pop();
        rx_pop = 1; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, enable register and status
        cur_req = "R1";
        idle(2);
        @(negedge clk) rst_n = 1;
        reg_addr = 2'd0; idle(1);
        reg_addr = 2'd1; idle(1);
        reg_addr = 2'd2; idle(1);
        // R1: events with all enables cleared keep irq low
        msr_change = 1; tick();
        rx_overrun = 1; tick();
        push(0); idle(2);
        rd(1); rd(2); rd(3);
        pop(); idle(1);

        // R10: enhanced bits gated by enh_en
        cur_req = "R10";
        wr_ier('h7F); reg_addr = 2'd0; idle(1);
        enh_en = 1; wr_ier('h70); idle(1);
        enh_en = 0; wr_ier('h00); idle(1);
        enh_en = 1; wr_ier('h00); enh_en = 0; idle(1);

        // R2 R8: receive data in non-FIFO and FIFO mode
        cur_req = "R2";
        fifo_en = 0; wr_ier('h01); reg_addr = 2'd1;
        push(0); idle(1); push(0); idle(1);
        cur_req = "R8";
        pop(); idle(1); pop(); idle(2);
        fifo_en = 1; push(0); idle(1);
        rx_trig_hit = 1; idle(2); rx_trig_hit = 0; idle(1);
        pop(); wr_ier(0);

        // R4 R6: head flags and error-in-queue bit
        cur_req = "R4";
        reg_addr = 2'd1;
        push(1); push(0); push(4); push(2); idle(1);
        rd(1);
        cur_req = "R6";
        pop(); idle(1); pop(); idle(1); pop(); idle(1);
        rd(1); pop(); idle(2);
        rd(1); rd(2);

        // R7: report point at head
        cur_req = "R7";
        err_on_arrival = 0; wr_ier('h04); reg_addr = 2'd2;
        push(0); push(2); idle(2);
        pop(); idle(2);
        rd(1); idle(1);
        push(1); pop(); idle(2);
        rd(1); pop(); idle(1); rd(1);
        // R7: report point at arrival
        err_on_arrival = 1;
        push(0); idle(1); push(4); idle(2);
        rd(1); pop(); pop(); idle(1); rd(1);
        err_on_arrival = 0;

        // R3: overrun flag and line-status source
        cur_req = "R3";
        reg_addr = 2'd1;
        rx_overrun = 1; tick(); idle(1);
        rd(1); idle(1);
        rx_overrun = 1; reg_rd = 1; reg_addr = 2'd1; tick(); idle(1);
        rd(1); wr_ier(0);

        // R9: transmit source
        cur_req = "R9";
        fifo_en = 0; tx_hold_empty = 1; reg_addr = 2'd2;
        rd(2); idle(1);
        wr_ier('h02); idle(1);
        thr_wr = 1; tx_hold_empty = 0; tick(); idle(1);
        tx_hold_empty = 1; idle(2);
        rd(2); idle(1);
        wr_ier(0); idle(1);
        tx_hold_empty = 0; wr_ier('h02); idle(1);
        wr_ier(0); tx_hold_empty = 1; wr_ier('h02); idle(1);
        thr_wr = 1; tick();
        fifo_en = 1; tx_below_trig = 0; idle(1);
        tx_below_trig = 1; idle(2);
        thr_wr = 1; tx_below_trig = 0; tick(); idle(1);
        wr_ier(0); fifo_en = 0;

        // R5: transmit empty bits
        cur_req = "R5";
        reg_addr = 2'd1;
        tx_hold_empty = 0; tx_shift_empty = 0; idle(1);
        tx_hold_empty = 1; idle(1);
        tx_shift_empty = 1; idle(1);
        tx_hold_empty = 0; idle(1);
        tx_hold_empty = 1; rd(2);

        // R11 R12: modem, xoff, rts sources and their clears
        cur_req = "R11";
        enh_en = 1; wr_ier('h68); enh_en = 0; reg_addr = 2'd2;
        msr_change = 1; tick(); idle(1);
        rd(2); rd(3); idle(1);
        xoff_rx = 1; tick(); idle(1);
        rd(3); rd(2); idle(1);
        rts_n = 0; idle(2); rts_n = 1; idle(2);
        cur_req = "R12";
        msr_change = 1; reg_rd = 1; reg_addr = 2'd3; tick();
        reg_addr = 2'd2; idle(1);
        xoff_rx = 1; reg_rd = 1; tick(); idle(1);
        rd(2); rd(3); idle(1);
        enh_en = 1; wr_ier(0); enh_en = 0;
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule